// File: doc/BRIEF.md
# DQS Delay Tap Centring Engine

This block searches for the range of delay-tap settings at which a memory read strobe samples data correctly, then places the tap in the middle of that range. A start pulse loads the tap setting that is in use now. The engine tries candidate settings one at a time. For each candidate it drives the value to both strobe lanes and asks an external comparison unit, through a request/acknowledge handshake, whether a stored test pattern reads back correctly. It first walks upward from the initial setting until a trial fails or the upper limit is reached. It then jumps back to the initial setting and walks downward until a trial fails or zero is reached. When the search ends, lane 0 receives the midpoint of the two edges and lane 1 receives the midpoint plus one.

The block also holds a pure combinational generator for the test data. It expands each bit of an 8-bit index into a 16-bit half-word, so a test routine can fill the memory region with patterns that toggle whole half-lanes. The memory accesses and the comparison are outside the block.

Top module: `dqs_tap_calib`

## Requirements
- R1: When idle, a `cal_start` pulse loads `cal_init_tap`. On the next clock `cal_busy` is 1 and both tap outputs equal the loaded value.
- R2: During the search, each candidate is driven identically on `tap0_o` and `tap1_o` before its first checker request, and both outputs stay equal while `cal_busy` is 1.
- R3: A trial consists of up to two checker runs. `chk_req` is held until `chk_ack` is seen, and `chk_pass` is sampled with `chk_ack`. After each acknowledge, `chk_req` drops for at least one cycle. A failed run ends the trial as a failure without a second request. The trial passes only when both runs pass.
- R4: In the upward phase, a passing trial whose candidate is below 0x20 makes the next candidate equal to the candidate plus one.
- R5: In the upward phase, a passing trial at 0x20 or above records the upper edge as that candidate and restarts at the initial tap in the downward phase.
- R6: In the upward phase, a failing trial records the upper edge as the candidate minus one, modulo 64, and restarts at the initial tap in the downward phase.
- R7: In the downward phase, a failing trial records the lower edge as the candidate plus one and ends the search.
- R8: In the downward phase, a passing trial at 0 records the lower edge as 0 and ends the search. Any other passing trial makes the next candidate equal to the candidate minus one.
- R9: At the end of the search, `tap0_o` is floor((upper + lower) / 2), with the sum formed in 7 bits, and `tap1_o` is that value plus one, modulo 64.
- R10: `cal_busy` falls and `cal_done` is high for exactly one cycle in the same cycle that the final taps appear. The final taps then hold.
- R11: A `cal_start` pulse while `cal_busy` is 1 is ignored and does not change the outcome of the search.
- R12: `pat_data` for index i and word select k has bits 15:0 all equal to bit 2k of i and bits 31:16 all equal to bit 2k+1 of i.
- R13: After reset, both taps are 0 and `cal_busy`, `cal_done` and `chk_req` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cal_start | input | 1 | Start pulse for a search |
| cal_init_tap | input | 6 | Tap setting in use at start |
| tap0_o | output | 6 | Delay tap for strobe lane 0 |
| tap1_o | output | 6 | Delay tap for strobe lane 1 |
| cal_busy | output | 1 | Search in progress |
| cal_done | output | 1 | One-cycle completion pulse |
| chk_req | output | 1 | Request a pattern comparison |
| chk_ack | input | 1 | Comparison finished (one-cycle pulse) |
| chk_pass | input | 1 | Comparison result, valid with chk_ack |
| pat_index | input | 8 | Pattern index |
| pat_word_sel | input | 2 | Word within the index |
| pat_data | output | 32 | Generated test word |

## Verification
The bench models a passing window, lo..hi, in the comparison unit. Several window placements are used. In one the initial tap lies inside a bounded window, which exercises failing edges on both sides. In another the window is fully open, so the search is capped at 0x20 and stops at zero. In a third the initial tap lies outside the window, so the very first trial fails and the midpoint falls back onto the start value. One case starts above 0x20, showing that the cap is checked only after a pass. Another makes a candidate fail only on its second run, which separates a design that reads a single run from one that needs both. Random windows, start values and acknowledge delays then check every candidate in order against a model of the requirements.

// File: rtl/dqs_cal_pkg.sv
package dqs_cal_pkg;
  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_LAUNCH = 2'd1,
    S_WAIT   = 2'd2,
    S_FINAL  = 2'd3
  } search_state_e;

  typedef enum logic [1:0] {
    T_IDLE = 2'd0,
    T_REQ  = 2'd1,
    T_GAP  = 2'd2
  } trial_state_e;
endpackage

// File: rtl/dqs_pattern_gen.sv
module dqs_pattern_gen #(
  parameter int WORDS_PER_IDX = 4,
  parameter int WORD_BITS     = 32,
  localparam int IDX_W  = 2 * WORDS_PER_IDX,
  localparam int SEL_W  = $clog2(WORDS_PER_IDX),
  localparam int HALF_W = WORD_BITS / 2
) (
  input  logic [IDX_W-1:0]     idx_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic [WORD_BITS-1:0] data_o
);
  logic [IDX_W-1:0] shifted;

  // each word consumes two index bits: low half from the even bit, high from the odd
  always_comb begin
    shifted = idx_i >> {sel_i, 1'b0};
    data_o  = {{HALF_W{shifted[1]}}, {HALF_W{shifted[0]}}};
  end
endmodule

// File: rtl/dqs_trial_seq.sv
module dqs_trial_seq
  import dqs_cal_pkg::*;
#(
  parameter int NUM_RUNS = 2,
  localparam int RUN_W = (NUM_RUNS > 1) ? $clog2(NUM_RUNS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trial_go,
  output logic chk_req,
  input  logic chk_ack,
  input  logic chk_pass,
  output logic trial_done,
  output logic trial_pass
);
  trial_state_e     state_q, state_d;
  logic [RUN_W-1:0] run_q, run_d;
  logic             done_q, done_d;
  logic             pass_q, pass_d;

  always_comb begin
    state_d = state_q;
    run_d   = run_q;
    done_d  = 1'b0;
    pass_d  = pass_q;
    case (state_q)
      T_IDLE: begin
        if (trial_go) begin
          state_d = T_REQ;
          run_d   = '0;
        end
      end
      T_REQ: begin
        if (chk_ack) begin
          if (!chk_pass) begin
            state_d = T_IDLE;
            done_d  = 1'b1;
            pass_d  = 1'b0;
          end else if (run_q == RUN_W'(NUM_RUNS - 1)) begin
            state_d = T_IDLE;
            done_d  = 1'b1;
            pass_d  = 1'b1;
          end else begin
            run_d   = run_q + 1'b1;
            state_d = T_GAP;
          end
        end
      end
      T_GAP:   state_d = T_REQ;
      default: state_d = T_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= T_IDLE;
      run_q   <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= run_d;
      done_q  <= done_d;
      pass_q  <= pass_d;
    end
  end

  assign chk_req    = (state_q == T_REQ);
  assign trial_done = done_q;
  assign trial_pass = pass_q;

  // R3: request held until acknowledged
  assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && !chk_ack) |=> chk_req);
  // R3: a failing run is never followed directly by another request
  assert_fail_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_req && chk_ack && !chk_pass) |=> (!chk_req && trial_done && !trial_pass));
endmodule

// File: rtl/dqs_edge_search.sv
module dqs_edge_search
  import dqs_cal_pkg::*;
#(
  parameter int TAP_W     = 6,
  parameter int TAP_LIMIT = 32,
  localparam int SUM_W = TAP_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TAP_W-1:0] init_tap,
  input  logic             trial_done,
  input  logic             trial_pass,
  output logic             trial_go,
  output logic [TAP_W-1:0] tap0_o,
  output logic [TAP_W-1:0] tap1_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam logic [TAP_W-1:0] LIM = TAP_W'(TAP_LIMIT);

  search_state_e    state_q, state_d;
  logic [TAP_W-1:0] start_q, start_d;
  logic [TAP_W-1:0] cur_q, cur_d;
  logic [TAP_W-1:0] upper_q, upper_d;
  logic [TAP_W-1:0] lower_q, lower_d;
  logic             up_q, up_d;
  logic [TAP_W-1:0] tap0_q, tap0_d;
  logic [TAP_W-1:0] tap1_q, tap1_d;
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic [SUM_W-1:0] edge_sum;
  logic [TAP_W-1:0] mid;

  assign edge_sum = {1'b0, upper_q} + {1'b0, lower_q};
  assign mid      = edge_sum[SUM_W-1:1];

  always_comb begin
    state_d = state_q;
    start_d = start_q;
    cur_d   = cur_q;
    upper_d = upper_q;
    lower_d = lower_q;
    up_d    = up_q;
    tap0_d  = tap0_q;
    tap1_d  = tap1_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          start_d = init_tap;
          cur_d   = init_tap;
          up_d    = 1'b1;
          tap0_d  = init_tap;
          tap1_d  = init_tap;
          busy_d  = 1'b1;
          state_d = S_LAUNCH;
        end
      end
      S_LAUNCH: state_d = S_WAIT;
      S_WAIT: begin
        if (trial_done) begin
          state_d = S_LAUNCH;
          if (up_q) begin
            if (trial_pass && (cur_q < LIM)) begin
              cur_d = cur_q + 1'b1;
            end else begin
              upper_d = trial_pass ? cur_q : (cur_q - 1'b1);
              up_d    = 1'b0;
              cur_d   = start_q;
            end
          end else if (!trial_pass) begin
            lower_d = cur_q + 1'b1;
            state_d = S_FINAL;
          end else if (cur_q == '0) begin
            lower_d = '0;
            state_d = S_FINAL;
          end else begin
            cur_d = cur_q - 1'b1;
          end
          if (state_d == S_LAUNCH) begin
            tap0_d = cur_d;
            tap1_d = cur_d;
          end
        end
      end
      S_FINAL: begin
        tap0_d  = mid;
        tap1_d  = mid + 1'b1;
        busy_d  = 1'b0;
        done_d  = 1'b1;
        state_d = S_IDLE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      start_q <= '0;
      cur_q   <= '0;
      upper_q <= '0;
      lower_q <= '0;
      up_q    <= 1'b0;
      tap0_q  <= '0;
      tap1_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= start_d;
      cur_q   <= cur_d;
      upper_q <= upper_d;
      lower_q <= lower_d;
      up_q    <= up_d;
      tap0_q  <= tap0_d;
      tap1_q  <= tap1_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign trial_go = (state_q == S_LAUNCH);
  assign tap0_o   = tap0_q;
  assign tap1_o   = tap1_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;

  // R2: both lanes carry the same candidate throughout the search
  assert_taps_equal_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (tap0_q == tap1_q));
  // R4: upward walk never passes the limit when started at or below it
  assert_up_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && up_q && (start_q <= LIM)) |-> (cur_q <= LIM));
  // R9: lane 1 sits one step above lane 0 on completion
  assert_lane_offset_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (tap1_q == TAP_W'(tap0_q + 1'b1)));
  // R10: completion pulse coincides with busy falling, and lasts one cycle
  assert_done_edge_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (!busy_q && $past(busy_q)));
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/dqs_tap_calib.sv
module dqs_tap_calib #(
  parameter int TAP_W         = 6,
  parameter int TAP_LIMIT     = 32,
  parameter int NUM_RUNS      = 2,
  parameter int WORDS_PER_IDX = 4,
  parameter int WORD_BITS     = 32,
  localparam int IDX_W = 2 * WORDS_PER_IDX,
  localparam int SEL_W = $clog2(WORDS_PER_IDX)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cal_start,
  input  logic [TAP_W-1:0]     cal_init_tap,
  output logic [TAP_W-1:0]     tap0_o,
  output logic [TAP_W-1:0]     tap1_o,
  output logic                 cal_busy,
  output logic                 cal_done,
  output logic                 chk_req,
  input  logic                 chk_ack,
  input  logic                 chk_pass,
  input  logic [IDX_W-1:0]     pat_index,
  input  logic [SEL_W-1:0]     pat_word_sel,
  output logic [WORD_BITS-1:0] pat_data
);
  logic trial_go;
  logic trial_done;
  logic trial_pass;

  dqs_edge_search #(
    .TAP_W     (TAP_W),
    .TAP_LIMIT (TAP_LIMIT)
  ) u_search (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (cal_start),
    .init_tap   (cal_init_tap),
    .trial_done (trial_done),
    .trial_pass (trial_pass),
    .trial_go   (trial_go),
    .tap0_o     (tap0_o),
    .tap1_o     (tap1_o),
    .busy_o     (cal_busy),
    .done_o     (cal_done)
  );

  dqs_trial_seq #(
    .NUM_RUNS (NUM_RUNS)
  ) u_trial (
    .clk        (clk),
    .rst_n      (rst_n),
    .trial_go   (trial_go),
    .chk_req    (chk_req),
    .chk_ack    (chk_ack),
    .chk_pass   (chk_pass),
    .trial_done (trial_done),
    .trial_pass (trial_pass)
  );

  dqs_pattern_gen #(
    .WORDS_PER_IDX (WORDS_PER_IDX),
    .WORD_BITS     (WORD_BITS)
  ) u_pattern (
    .idx_i  (pat_index),
    .sel_i  (pat_word_sel),
    .data_o (pat_data)
  );
endmodule

// File: tb/dqs_tap_calib_tb.sv
module dqs_tap_calib_tb_top;
  logic        clk;
  logic        rst_n;
  logic        cal_start;
  logic [5:0]  cal_init_tap;
  logic [5:0]  tap0_o;
  logic [5:0]  tap1_o;
  logic        cal_busy;
  logic        cal_done;
  logic        chk_req;
  logic        chk_ack;
  logic        chk_pass;
  logic [7:0]  pat_index;
  logic [1:0]  pat_word_sel;
  logic [31:0] pat_data;

  int checks = 0;
  int errors = 0;

  // reference search state
  int    m_cur, m_start, m_upper, m_lower;
  bit    m_up, m_fin;
  string m_rule;

  dqs_tap_calib dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cal_start    (cal_start),
    .cal_init_tap (cal_init_tap),
    .tap0_o       (tap0_o),
    .tap1_o       (tap1_o),
    .cal_busy     (cal_busy),
    .cal_done     (cal_done),
    .chk_req      (chk_req),
    .chk_ack      (chk_ack),
    .chk_pass     (chk_pass),
    .pat_index    (pat_index),
    .pat_word_sel (pat_word_sel),
    .pat_data     (pat_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_pattern(input int idx, input int sel);
    bit lo, hi;
    lo = ((idx >> (2 * sel)) & 1) != 0;
    hi = ((idx >> (2 * sel + 1)) & 1) != 0;
    return {{16{hi}}, {16{lo}}};
  endfunction

  // advance the reference model by one trial result
  task automatic model_step(input bit p);
    if (m_up) begin
      if (p && m_cur < 32) begin
        m_cur++;
        m_rule = "R4";
      end else begin
        m_upper = p ? m_cur : ((m_cur - 1) & 63);
        m_rule  = p ? "R5" : "R6";
        m_up    = 1'b0;
        m_cur   = m_start;
      end
    end else if (!p) begin
      m_lower = (m_cur + 1) & 63;
      m_fin   = 1'b1;
      m_rule  = "R7";
    end else if (m_cur == 0) begin
      m_lower = 0;
      m_fin   = 1'b1;
      m_rule  = "R8";
    end else begin
      m_cur--;
      m_rule = "R8";
    end
  endtask

  task automatic run_cal(input int init, input int wlo, input int whi,
                         input int inj, input bit probe);
    int  run;
    int  cyc;
    int  d;
    int  mid;
    bit  p;
    m_cur = init; m_start = init; m_up = 1'b1; m_fin = 1'b0;
    m_upper = 0; m_lower = 0; m_rule = "R1";
    run = 0; cyc = 0;
    @(negedge clk);
    cal_start = 1'b1; cal_init_tap = 6'(init);
    @(negedge clk);
    cal_start = 1'b0;
    check(cal_busy == 1'b1, "R1", "busy after start", int'(cal_busy), 1);
    check(tap0_o == 6'(init) && tap1_o == 6'(init), "R1", "taps loaded",
          int'(tap0_o), init);
    if (probe) begin
      cal_start = 1'b1; cal_init_tap = 6'(init ^ 21);
      @(negedge clk);
      cal_start = 1'b0; cal_init_tap = 6'(init);
      check(cal_busy == 1'b1, "R11", "busy after second start", int'(cal_busy), 1);
    end
    while (!cal_done && cyc < 20000) begin
      cyc++;
      check(cal_busy == 1'b1, "R10", "busy during search", int'(cal_busy), 1);
      if (chk_req) begin
        if (run == 0) begin
          check(!m_fin, "R10", "request after model end", 1, 0);
          check(int'(tap0_o) == m_cur, m_rule, "candidate lane 0", int'(tap0_o), m_cur);
          check(tap1_o == tap0_o, "R2", "lane 1 equals lane 0", int'(tap1_o), int'(tap0_o));
        end
        d = $urandom_range(0, 3);
        repeat (d) begin
          @(negedge clk);
          check(chk_req == 1'b1, "R3", "request held", int'(chk_req), 1);
        end
        p = (int'(tap0_o) >= wlo) && (int'(tap0_o) <= whi) &&
            !(run == 1 && int'(tap0_o) == inj);
        chk_ack = 1'b1; chk_pass = p;
        @(negedge clk);
        chk_ack = 1'b0; chk_pass = 1'b0;
        check(chk_req == 1'b0, "R3", "request drops after ack", int'(chk_req), 0);
        if (!p || run == 1) begin
          model_step(p);
          run = 0;
        end else begin
          run = 1;
        end
      end else begin
        @(negedge clk);
      end
    end
    mid = ((m_upper + m_lower) >> 1) & 63;
    check(cal_done == 1'b1 && m_fin, "R10", "search completed", int'(cal_done), 1);
    check(cal_busy == 1'b0, "R10", "busy low at done", int'(cal_busy), 0);
    check(int'(tap0_o) == mid, "R9", {"final lane 0 after ", m_rule}, int'(tap0_o), mid);
    check(int'(tap1_o) == ((mid + 1) & 63), "R9", "final lane 1", int'(tap1_o),
          (mid + 1) & 63);
    @(negedge clk);
    check(cal_done == 1'b0, "R10", "done is one cycle", int'(cal_done), 0);
    check(int'(tap0_o) == mid, "R10", "final tap holds", int'(tap0_o), mid);
  endtask

  initial begin
    int seed;
    int lo, hi, st;
    logic [31:0] e;
    seed = $urandom(32'h5eed);
    rst_n = 1'b0; cal_start = 1'b0; cal_init_tap = '0;
    chk_ack = 1'b0; chk_pass = 1'b0; pat_index = '0; pat_word_sel = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(tap0_o == 0 && tap1_o == 0, "R13", "reset taps", int'(tap0_o), 0);
    check(!cal_busy && !cal_done && !chk_req, "R13", "reset flags",
          int'({cal_busy, cal_done, chk_req}), 0);

    // pattern generator: directed extremes then random indices
    for (int k = 0; k < 4; k++) begin
      pat_index = 8'hFF; pat_word_sel = 2'(k); #1;
      check(pat_data == 32'hFFFF_FFFF, "R12", "pattern all ones", int'(pat_data), -1);
      pat_index = 8'h00; #1;
      check(pat_data == 32'h0, "R12", "pattern all zeros", int'(pat_data), 0);
    end
    for (int n = 0; n < 40; n++) begin
      pat_index = 8'($urandom_range(0, 255));
      pat_word_sel = 2'($urandom_range(0, 3));
      #1;
      e = exp_pattern(int'(pat_index), int'(pat_word_sel));
      check(pat_data == e, "R12", "pattern word", int'(pat_data), int'(e));
    end

    // directed searches
    run_cal(8, 3, 12, -1, 1'b0);    // bounded window both sides
    run_cal(30, 0, 63, -1, 1'b0);   // capped at limit, stops at zero
    run_cal(5, 10, 20, -1, 1'b0);   // first trial fails upward
    run_cal(8, 3, 12, 10, 1'b0);    // second run fails at 10
    run_cal(8, 3, 12, -1, 1'b1);    // restart attempt while busy
    run_cal(37, 0, 63, -1, 1'b0);   // start above the limit
    run_cal(0, 0, 5, -1, 1'b0);     // reaches zero immediately downward

    // random windows and start points
    for (int n = 0; n < 30; n++) begin
      lo = $urandom_range(0, 30);
      hi = lo + $urandom_range(0, 33);
      if (hi > 63) hi = 63;
      st = $urandom_range(0, 32);
      run_cal(st, lo, hi, (n % 3 == 0) ? $urandom_range(0, 40) : -1, n % 5 == 0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule